// File: doc/BRIEF.md
# Two-Channel Playback Command Sequencer

This block sits between a host byte port and two playback engines. The host sends bytes, each tagged as either a command byte or a data byte. The block decodes a command set in which some commands are one byte and others take a second data byte. From those commands it drives per-channel control outputs: a start pulse with a phrase number, a stop pulse, a loop enable, a silence pulse with a length, and a volume level.

Each channel tracks two things: whether it is playing, and whether a phrase is queued behind the current one. The engines report the end of each phrase on a per-channel input. A channel can also be loaded with a phrase number ahead of time, so that one start command launches several channels in the same cycle.

The host reads a status byte that carries an active-low busy flag and an active-low ready flag for each channel. All four flags read low while a command is being taken in or processed.

Top module: `dual_play_sequencer`

## Requirements
- R1: After reset, the status byte is 0x0F, all pulses are low, loop enables are low and both volumes are 0.
- R2: Play (upper nibble 0x4, then a phrase byte) on a channel that is not playing gives a one-cycle start pulse carrying that phrase. The channel's busy flag then stays low until an end-of-phrase input arrives with nothing queued and loop off.
- R3: Play on a channel that is already playing queues the phrase and drives that channel's ready flag low. The next end-of-phrase starts the queued phrase with a start pulse and drives ready high again.
- R4: Preload (0x6, then a phrase byte) stores a phrase for each channel in the mask. Start (0x5) then pulses every masked channel in the same cycle, each with its own stored phrase.
- R5: Stop (0x7) gives a one-cycle stop pulse on each masked channel and ends playback there. It also clears loop mode and drops any queued phrase on that channel.
- R6: Loop on (0x9) takes effect only on a channel that is playing, and loop off (0xA) clears it. While loop is on, end-of-phrase restarts the same phrase with a start pulse and the channel stays busy.
- R7: Silence (0x8, then a length byte) gives a one-cycle silence pulse on each masked channel and presents the length byte.
- R8: Volume (0xB, then a byte) loads the low 5 bits of the data byte into the volume output of each masked channel.
- R9: In a channel command, bit 0 selects channel 1 and bit 1 selects channel 2. A mask of 00 changes nothing.
- R10: The status byte is {4'b0, busy2, busy1, ready2, ready1}, with flags active low. All four flags read low while the second byte of a command is awaited, and for exactly 4 cycles after the last byte of any command, including the power and external-data commands.
- R11: A command byte that arrives while a second byte is awaited abandons the earlier command without effect. A data byte that arrives when no second byte is awaited is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_vld | input | 1 | Host byte present this cycle |
| host_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| host_byte | input | 8 | Host byte |
| phrase_end | input | 2 | End-of-phrase from the engines, bit 0 = channel 1 |
| status_byte | output | 8 | Channel status byte |
| start_pulse | output | 2 | One-cycle start per channel |
| phrase_num | output | 16 | Phrase per channel, channel 1 in bits 7:0 |
| stop_pulse | output | 2 | One-cycle stop per channel |
| loop_en | output | 2 | Loop mode per channel |
| sil_pulse | output | 2 | One-cycle silence request per channel |
| sil_len | output | 16 | Silence length per channel, channel 1 in bits 7:0 |
| vol_level | output | 10 | Volume per channel, channel 1 in bits 4:0 |

## Verification
The hardest cases to reach are those where a command lands on a channel whose state the engines have just changed. Examples are a queued phrase that must survive a stop or be released by an end-of-phrase, and a loop request on a channel that has just gone idle. The bench gets there in sequence. It starts a phrase, issues a second play so that ready drops, then pulses the engine's end input or sends a stop, and reads both the start pulses and the status byte. Abandoned two-byte commands are provoked by sending a new command byte straight after the first byte of a play.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;
   localparam int NCH = 2;
   localparam int BW  = 8;

   typedef enum logic [3:0] {
      OP_PWRUP_FAST  = 4'h0,
      OP_PWRUP_SOFT  = 4'h1,
      OP_PWRDN_FAST  = 4'h2,
      OP_PWRDN_SOFT  = 4'h3,
      OP_PLAY        = 4'h4,
      OP_START       = 4'h5,
      OP_PRELOAD     = 4'h6,
      OP_STOP        = 4'h7,
      OP_SILENCE     = 4'h8,
      OP_LOOP_ON     = 4'h9,
      OP_LOOP_OFF    = 4'hA,
      OP_VOLUME      = 4'hB,
      OP_EXTDATA     = 4'hC
   } op_e;

   typedef struct packed {
      logic            fire;
      logic [3:0]      op;
      logic [NCH-1:0]  mask;
      logic [BW-1:0]   arg;
   } action_t;

   function automatic logic takes_arg(input logic [3:0] op);
      return (op == OP_PLAY) || (op == OP_PRELOAD) ||
             (op == OP_SILENCE) || (op == OP_VOLUME);
   endfunction
endpackage

// File: rtl/cmdseq_decode.sv
module cmdseq_decode
   import cmdseq_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          byte_vld,
   input  logic          byte_is_cmd,
   input  logic [BW-1:0] byte_in,
   output action_t       act,
   output logic          awaiting
);
   logic [3:0]     held_op;
   logic [NCH-1:0] held_mask;

   always_comb begin
      act = '0;
      if (byte_vld) begin
         if (byte_is_cmd) begin
            if (!takes_arg(byte_in[7:4])) begin
               act.fire = 1'b1;
               act.op   = byte_in[7:4];
               act.mask = byte_in[NCH-1:0];
            end
         end else if (awaiting) begin
            act.fire = 1'b1;
            act.op   = held_op;
            act.mask = held_mask;
            act.arg  = byte_in;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         awaiting  <= 1'b0;
         held_op   <= '0;
         held_mask <= '0;
      end else if (byte_vld) begin
         if (byte_is_cmd) begin
            awaiting  <= takes_arg(byte_in[7:4]);
            held_op   <= byte_in[7:4];
            held_mask <= byte_in[NCH-1:0];
         end else begin
            awaiting  <= 1'b0;
         end
      end
   end

   // R11: a stray data byte never leaves a command pending
   a_r11_stray_data_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_is_cmd) |=> !awaiting);
endmodule

// File: rtl/cmdseq_proc_timer.sv
module cmdseq_proc_timer #(
   parameter int CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic active
);
   localparam int CW = $clog2(CYC + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= CW'(CYC);
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);

   // R10: window counter never leaves its range
   a_r10_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(CYC));
   a_r10_window_starts: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> active);
endmodule

// File: rtl/cmdseq_chan.sv
module cmdseq_chan
   import cmdseq_pkg::*;
#(
   parameter int IDX     = 0,
   parameter int VW      = 5,
   parameter int VOL_RST = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  action_t       act,
   input  logic          eop,
   output logic          start_p,
   output logic [BW-1:0] phrase_o,
   output logic          stop_p,
   output logic          loop_o,
   output logic          sil_p,
   output logic [BW-1:0] sil_len_o,
   output logic [VW-1:0] vol_o,
   output logic          playing_o,
   output logic          queued_o
);
   logic          sel;
   logic          still_playing;
   logic [BW-1:0] queued_phr;
   logic [BW-1:0] pre_phr;

   assign sel           = act.fire && act.mask[IDX];
   assign still_playing = playing_o && !(eop && !queued_o && !loop_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_p    <= 1'b0;
         stop_p     <= 1'b0;
         sil_p      <= 1'b0;
         phrase_o   <= '0;
         loop_o     <= 1'b0;
         sil_len_o  <= '0;
         vol_o      <= VW'(VOL_RST);
         playing_o  <= 1'b0;
         queued_o   <= 1'b0;
         queued_phr <= '0;
         pre_phr    <= '0;
      end else begin
         start_p <= 1'b0;
         stop_p  <= 1'b0;
         sil_p   <= 1'b0;
         if (eop && playing_o) begin
            if (queued_o) begin
               start_p  <= 1'b1;
               phrase_o <= queued_phr;
               queued_o <= 1'b0;
            end else if (loop_o) begin
               start_p  <= 1'b1;
            end else begin
               playing_o <= 1'b0;
            end
         end
         if (sel) begin
            case (act.op)
               OP_PLAY: begin
                  if (still_playing) begin
                     queued_o   <= 1'b1;
                     queued_phr <= act.arg;
                  end else begin
                     start_p   <= 1'b1;
                     phrase_o  <= act.arg;
                     playing_o <= 1'b1;
                  end
               end
               OP_START: begin
                  start_p   <= 1'b1;
                  phrase_o  <= pre_phr;
                  playing_o <= 1'b1;
               end
               OP_PRELOAD:  pre_phr <= act.arg;
               OP_STOP: begin
                  start_p   <= 1'b0;
                  stop_p    <= 1'b1;
                  playing_o <= 1'b0;
                  queued_o  <= 1'b0;
                  loop_o    <= 1'b0;
               end
               OP_SILENCE: begin
                  sil_p     <= 1'b1;
                  sil_len_o <= act.arg;
               end
               OP_LOOP_ON:  if (still_playing) loop_o <= 1'b1;
               OP_LOOP_OFF: loop_o <= 1'b0;
               OP_VOLUME:   vol_o  <= act.arg[VW-1:0];
               default: ;
            endcase
         end
      end
   end

   // R5: stop leaves the channel idle with loop and queue cleared
   a_r5_stop_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && act.op == OP_STOP) |=> (stop_p && !loop_o && !playing_o && !queued_o));
   // R6: loop mode exists only on a playing channel
   a_r6_loop_needs_play: assert property (@(posedge clk) disable iff (!rst_n)
      loop_o |-> playing_o);
   // R3: a queued phrase always sits behind a playing one
   a_r3_queue_needs_play: assert property (@(posedge clk) disable iff (!rst_n)
      queued_o |-> playing_o);
   // R2: a start pulse leaves the channel playing
   a_r2_start_plays: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |-> playing_o);
endmodule

// File: rtl/dual_play_sequencer.sv
module dual_play_sequencer
   import cmdseq_pkg::*;
#(
   parameter int VOL_W       = 5,
   parameter int VOL_RESET   = 0,
   parameter int PROC_CYCLES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_vld,
   input  logic                 host_is_cmd,
   input  logic [7:0]           host_byte,
   input  logic [1:0]           phrase_end,
   output logic [7:0]           status_byte,
   output logic [1:0]           start_pulse,
   output logic [15:0]          phrase_num,
   output logic [1:0]           stop_pulse,
   output logic [1:0]           loop_en,
   output logic [1:0]           sil_pulse,
   output logic [15:0]          sil_len,
   output logic [2*VOL_W-1:0]   vol_level
);
   localparam int PAD_W = BW - 2 * NCH;

   if (VOL_W < 1 || VOL_W > BW) begin : g_bad_vol
      $error("VOL_W must lie in 1..8");
   end
   if (PROC_CYCLES < 1) begin : g_bad_proc
      $error("PROC_CYCLES must be at least 1");
   end

   action_t        act;
   logic           awaiting;
   logic           timer_active;
   logic           proc;
   logic [NCH-1:0] playing, queued;

   cmdseq_decode u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_vld    (host_vld),
      .byte_is_cmd (host_is_cmd),
      .byte_in     (host_byte),
      .act         (act),
      .awaiting    (awaiting)
   );

   cmdseq_proc_timer #(.CYC(PROC_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (act.fire),
      .active (timer_active)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      cmdseq_chan #(.IDX(c), .VW(VOL_W), .VOL_RST(VOL_RESET)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .act       (act),
         .eop       (phrase_end[c]),
         .start_p   (start_pulse[c]),
         .phrase_o  (phrase_num[c*BW +: BW]),
         .stop_p    (stop_pulse[c]),
         .loop_o    (loop_en[c]),
         .sil_p     (sil_pulse[c]),
         .sil_len_o (sil_len[c*BW +: BW]),
         .vol_o     (vol_level[c*VOL_W +: VOL_W]),
         .playing_o (playing[c]),
         .queued_o  (queued[c])
      );
   end

   assign proc        = timer_active || awaiting;
   assign status_byte = {{PAD_W{1'b0}},
                         ~(playing | {NCH{proc}}),
                         ~(queued  | {NCH{proc}})};

   // R10: every finished command pulls the flags low on the next cycle
   a_r10_flags_low_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      act.fire |=> (status_byte[3:0] == 4'b0000));
   // R10: upper status bits are always zero
   a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[7:4] == 4'b0000);
endmodule

// File: tb/dual_play_sequencer_tb.sv
`timescale 1ns/100ps
module dual_play_sequencer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_vld = 1'b0;
   logic        host_is_cmd = 1'b0;
   logic [7:0]  host_byte = '0;
   logic [1:0]  phrase_end = '0;
   logic [7:0]  status_byte;
   logic [1:0]  start_pulse, stop_pulse, loop_en, sil_pulse;
   logic [15:0] phrase_num, sil_len;
   logic [9:0]  vol_level;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dual_play_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .host_vld(host_vld), .host_is_cmd(host_is_cmd),
      .host_byte(host_byte), .phrase_end(phrase_end), .status_byte(status_byte),
      .start_pulse(start_pulse), .phrase_num(phrase_num), .stop_pulse(stop_pulse),
      .loop_en(loop_en), .sil_pulse(sil_pulse), .sil_len(sil_len), .vol_level(vol_level)
   );

   task automatic chk(input logic [31:0] actual, input logic [31:0] expect_v, input string what);
      n_chk++;
      if (actual !== expect_v) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", what, actual, expect_v);
      end
   endtask

   // drive at a negedge, return at the next negedge with the byte taken
   task automatic put(input logic is_cmd, input logic [7:0] b);
      host_vld = 1'b1; host_is_cmd = is_cmd; host_byte = b;
      @(negedge clk);
      host_vld = 1'b0; host_is_cmd = 1'b0; host_byte = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic eop(input logic [1:0] m);
      phrase_end = m;
      @(negedge clk);
      phrase_end = '0;
   endtask

   task automatic t_reset;
      chk(status_byte, 8'h0F, "R1 status after reset");
      chk(start_pulse | stop_pulse | sil_pulse, 0, "R1 pulses after reset");
      chk(loop_en, 0, "R1 loop after reset");
      chk(vol_level, 0, "R1 volume after reset");
   endtask

   task automatic t_play_idle;
      put(1, 8'h41); put(0, 8'h23);
      chk(start_pulse, 2'b01, "R2 R9 start pulse on channel 1 only");
      chk(phrase_num[7:0], 8'h23, "R2 phrase number");
      chk(status_byte, 8'h00, "R10 flags low cycle 1");
      idle(1); chk(start_pulse, 2'b00, "R2 start pulse lasts one cycle");
      idle(2); chk(status_byte, 8'h00, "R10 flags low cycle 4");
      idle(1); chk(status_byte, 8'h0B, "R10 R2 window over, busy1 low");
      eop(2'b01);
      chk(status_byte, 8'h0F, "R2 end of phrase frees channel 1");
   endtask

   task automatic t_queue;
      put(1, 8'h42); put(0, 8'h10); idle(4);
      put(1, 8'h42); put(0, 8'h11);
      chk(start_pulse, 2'b00, "R3 play on busy channel does not start");
      idle(4);
      chk(status_byte, 8'h05, "R3 ready2 low while queued");
      eop(2'b10);
      chk(start_pulse, 2'b10, "R3 queued phrase starts at end");
      chk(phrase_num[15:8], 8'h11, "R3 queued phrase number");
      chk(status_byte, 8'h07, "R3 ready2 back high");
      eop(2'b10);
      chk(status_byte, 8'h0F, "R3 channel 2 idle after second end");
   endtask

   task automatic t_sync_start;
      put(1, 8'h61); put(0, 8'h55);
      put(1, 8'h62); put(0, 8'h66);
      chk(start_pulse, 2'b00, "R4 preload alone does not start");
      put(1, 8'h53);
      chk(start_pulse, 2'b11, "R4 both channels start together");
      chk(phrase_num, 16'h6655, "R4 preloaded phrases");
      idle(4);
      put(1, 8'h73);
      chk(stop_pulse, 2'b11, "R5 stop pulses both channels");
      idle(4);
      chk(status_byte, 8'h0F, "R5 both idle after stop");
   endtask

   task automatic t_loop;
      put(1, 8'h91);
      chk(loop_en, 2'b00, "R6 loop on idle channel ignored");
      put(1, 8'h41); put(0, 8'h07); put(1, 8'h91);
      chk(loop_en, 2'b01, "R6 loop on playing channel");
      idle(4);
      eop(2'b01);
      chk(start_pulse, 2'b01, "R6 loop restarts phrase");
      chk(phrase_num[7:0], 8'h07, "R6 loop keeps phrase");
      chk(status_byte, 8'h0B, "R6 channel stays busy");
      put(1, 8'hA1);
      chk(loop_en, 2'b00, "R6 loop off clears");
      put(1, 8'h91); put(1, 8'h71);
      chk(loop_en, 2'b00, "R5 stop clears loop");
      chk(stop_pulse, 2'b01, "R5 stop pulse channel 1");
      put(1, 8'h42); put(0, 8'h01); put(1, 8'h42); put(0, 8'h02);
      put(1, 8'h72); idle(4);
      chk(status_byte, 8'h0F, "R5 stop drops queue");
      eop(2'b10);
      chk(start_pulse, 2'b00, "R5 no start from dropped queue");
   endtask

   task automatic t_sil_vol;
      put(1, 8'h82); put(0, 8'h30);
      chk(sil_pulse, 2'b10, "R7 silence pulse channel 2");
      chk(sil_len[15:8], 8'h30, "R7 silence length");
      put(1, 8'hB1); put(0, 8'hFF);
      chk(vol_level, 10'd31, "R8 volume low five bits to channel 1");
      put(1, 8'hB0); put(0, 8'h0A);
      chk(vol_level, 10'd31, "R9 empty mask changes nothing");
      put(1, 8'h10);
      chk(status_byte, 8'h00, "R10 power command processed");
      idle(3); chk(status_byte, 8'h00, "R10 power window cycle 4");
      idle(1); chk(status_byte, 8'h0F, "R10 power window over");
   endtask

   task automatic t_abort;
      put(1, 8'h41);
      chk(status_byte, 8'h00, "R10 flags low while second byte awaited");
      put(1, 8'hB2);
      chk(start_pulse, 2'b00, "R11 abandoned play no start");
      put(0, 8'h09);
      chk(start_pulse, 2'b00, "R11 data goes to new command");
      chk(vol_level[9:5], 5'd9, "R11 volume from replacing command");
      idle(4);
      chk(status_byte, 8'h0F, "R11 channel 1 never started");
      put(0, 8'h44);
      chk(status_byte, 8'h0F, "R11 stray data ignored");
      chk(start_pulse | sil_pulse, 0, "R11 stray data no pulses");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset;
      t_play_idle;
      t_queue;
      t_sync_start;
      t_loop;
      t_sil_vol;
      t_abort;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule